// File: doc/BRIEF.md
# I2C Serial Memory Read Slave

This block is the read side of a serial memory: an I2C target that answers at one fixed 7-bit address and returns bytes from a 256-entry byte array. Open-drain SCL and SDA reach it as plain inputs. Both lines pass through two-flop synchronisers clocked by a fast system clock, and the bus edges are found from the synchronised levels. The block answers the bus only through a pull-down enable for SDA. A load port lets the surrounding environment fill the array directly. Bytes sent by the bus master are never stored.

The block keeps an 8-bit address counter from one transaction to the next. A read with no address phase continues from the byte after the last one accessed. A short write that carries only a byte address loads that counter without changing memory. A repeated START then reads from the loaded location. After every byte the master may ACK to get the following byte. Bursts can run past the top of the array and wrap to the bottom.

Top module: `i2c_rd_slave`

## Requirements
- R1: The target address is 7'b1010000, carried in the upper seven bits of the first byte after START, with bit 0 as the read flag (1 = read). On a match the block pulls SDA low for the ninth clock. On a mismatch SDA is never driven until the next START.
- R2: A read with no address phase returns the byte at the counter. After reset the counter is 0.
- R3: After a byte at location N goes out, the counter holds N+1. This holds whether the master answered that byte with ACK or NACK, so the next address-less read returns location N+1.
- R4: A write-flagged header followed by one address byte gets an ACK on both bytes and loads the counter. A repeated START and a read header then return that location.
- R5: A byte that follows the address byte in a write gets no ACK, and the memory keeps its contents.
- R6: Each master ACK on a data byte makes the block send the next sequential byte in the same transaction. One burst can stream all 256 locations.
- R7: The counter wraps from 255 to 0, and data read after the wrap is valid.
- R8: After a master NACK the block releases SDA and does not drive it again before a START or STOP.
- R9: A START or STOP at any bit position resets the bit and byte sequencing and leaves the counter unchanged.
- R10: SDA changes only while the synchronised SCL is low. Data bits go out MSB first and are sampled on the rising edge of SCL.
- R11: Reset releases SDA and clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| mem_we_i | input | 1 | Array load strobe |
| mem_addr_i | input | 8 | Array load location |
| mem_data_i | input | 8 | Array load data |

## Verification
The assertions assume a well-formed master. SCL stays stable for several system clocks around every SDA transition the master makes. START and STOP never arrive while the block is pulling SDA low. Every level lasts longer than the synchroniser delay, so each synchronised edge appears exactly once.

The bench keeps to these assumptions. It moves SDA only a quarter bit period after SCL falls, and it holds every phase for eight system clocks. It issues START and STOP only after the block has released SDA: after an ACK clock ends, after a NACK, or inside a bit the master owns.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_END,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_END,
    ST_WADDR_ACK,
    ST_TX,
    ST_TX_END,
    ST_MACK,
    ST_NEXT,
    ST_IGNORE
  } rd_state_e;
endpackage

// File: rtl/i2c_sync_edge.sv
module i2c_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // idle bus level is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              bus_start_i,
  input  logic              bus_stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [AW-1:0]     addr_o,
  output logic              addr_load_o,
  output rd_state_e         state_o
);
  localparam int          CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  rd_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              oe_q;
  logic              rw_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] rx_next;
  logic              bus_evt;
  logic              addr_inc;
  logic              addr_load;

  assign bus_evt   = bus_start_i | bus_stop_i;
  assign rx_next   = {rx_q[BYTE_W-2:0], sda_i};
  assign addr_load = !bus_evt && state_q == ST_WADDR && scl_rise_i && cnt_q == LAST;
  // advance once the last bit is clocked out, ahead of the master's answer
  assign addr_inc  = !bus_evt && state_q == ST_TX && scl_rise_i && cnt_q == LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_load) addr_q <= rx_next[AW-1:0];
    else if (addr_inc)  addr_q <= addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
    end else if (bus_evt) begin
      state_q <= bus_start_i ? ST_DEV : ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR: begin
          if (scl_rise_i) begin
            rx_q  <= rx_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST)
              state_q <= (state_q == ST_DEV) ? ST_DEV_END : ST_WADDR_END;
          end
        end
        ST_DEV_END: begin
          if (scl_fall_i) begin
            if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
              oe_q    <= 1'b1;
              rw_q    <= rx_q[0];
              state_q <= ST_DEV_ACK;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[BYTE_W-1];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADDR;
            end
          end
        end
        ST_WADDR_END: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b1;
            state_q <= ST_WADDR_ACK;
          end
        end
        ST_WADDR_ACK: begin
          // further write bytes are neither acknowledged nor stored
          if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_IGNORE;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= ST_TX_END;
          end else if (scl_fall_i) begin
            tx_q <= tx_q << 1;
            oe_q <= ~tx_q[BYTE_W-2];
          end
        end
        ST_TX_END: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise_i) state_q <= sda_i ? ST_IGNORE : ST_NEXT;
        end
        ST_NEXT: begin
          if (scl_fall_i) begin
            tx_q    <= rd_data_i;
            oe_q    <= ~rd_data_i[BYTE_W-1];
            cnt_q   <= '0;
            state_q <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o    = oe_q;
  assign addr_o      = addr_q;
  assign addr_load_o = addr_load;
  assign state_o     = state_q;
endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
  import i2c_rd_pkg::*;
#(
  parameter int         AW          = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [7:0]    mem_data_i
);
  logic [1:0]        lvl, rise, fall;
  logic              scl_lvl, sda_lvl;
  logic              start_evt, stop_evt;
  logic [AW-1:0]     addr_q;
  logic              addr_load;
  logic [BYTE_W-1:0] rd_data;
  rd_state_e         fsm_state;

  i2c_sync_edge #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign start_evt = fall[1] & scl_lvl;
  assign stop_evt  = rise[1] & scl_lvl;

  i2c_rd_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we_i),
    .waddr_i (mem_addr_i),
    .wdata_i (mem_data_i),
    .raddr_i (addr_q),
    .rdata_o (rd_data)
  );

  i2c_rd_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (rise[0]),
    .scl_fall_i  (fall[0]),
    .sda_i       (sda_lvl),
    .bus_start_i (start_evt),
    .bus_stop_i  (stop_evt),
    .rd_data_i   (rd_data),
    .sda_oe_o    (sda_oe_o),
    .addr_o      (addr_q),
    .addr_load_o (addr_load),
    .state_o     (fsm_state)
  );
endmodule

// File: rtl/i2c_rd_chk.sv
module i2c_rd_chk
  import i2c_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sda_oe_i,
  input logic          scl_lvl_i,
  input logic          start_i,
  input logic          stop_i,
  input logic [AW-1:0] addr_i,
  input logic          addr_load_i,
  input rd_state_e     state_i
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !scl_lvl_i); // R10

  AST_ADDR_KEPT_BUS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> (addr_i == $past(addr_i))); // R9

  AST_ADDR_STEP_OR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != $past(addr_i)) |-> ($past(addr_load_i) || addr_i == AW'($past(addr_i) + 1'b1))); // R7

  AST_RELEASED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE || state_i == ST_IGNORE || state_i == ST_MACK) |-> !sda_oe_i); // R8

  AST_ACK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DEV_ACK || state_i == ST_WADDR_ACK) |-> sda_oe_i); // R1
endmodule

bind i2c_rd_slave i2c_rd_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_oe_i    (sda_oe_o),
  .scl_lvl_i   (scl_lvl),
  .start_i     (start_evt),
  .stop_i      (stop_evt),
  .addr_i      (addr_q),
  .addr_load_i (addr_load),
  .state_i     (fsm_state)
);

// File: tb/tb_i2c_rd_slave.sv
module tb_i2c_rd_slave;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       dut_oe;
  logic       sda_line;
  logic       mem_we = 1'b0;
  logic [7:0] mem_addr = '0;
  logic [7:0] mem_data = '0;

  int checks = 0;
  int errors = 0;
  int exp_addr = 0;
  int r10_viol = 0;
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~dut_oe;

  i2c_rd_slave dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (dut_oe),
    .mem_we_i   (mem_we),
    .mem_addr_i (mem_addr),
    .mem_data_i (mem_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic clk_bit(input logic drv, output logic smp);
    m_sda = drv; wq(Q);
    m_scl = 1'b1; wq(Q);
    smp = sda_line; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(1'b1, b[i]);
    clk_bit(~mack, s);
  endtask

  task automatic open_read(input string req);
    logic ack;
    bus_start();
    send_byte(8'hA1, ack);
    check(ack, req, "read header ack", ack, 1);
  endtask

  task automatic set_addr(input int a);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack);
    check(ack, "R4", "write header ack", ack, 1);
    send_byte(8'(a), ack);
    check(ack, "R4", "address byte ack", ack, 1);
    exp_addr = a;
  endtask

  task automatic read_seq(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      check(b == pat(exp_addr), req, $sformatf("data @%0h", exp_addr), b, pat(exp_addr));
      exp_addr = (exp_addr + 1) & 255;
    end
  endtask

  task automatic idle_bits(input string req);
    logic s;
    int low = 0;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      if (!s) low++;
    end
    check(low == 0, req, "SDA pulled low while released", low, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R10: outputs may move only while SCL is low
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && dut_oe != prev_oe) r10_viol++;
    prev_scl = m_scl;
    prev_oe  = dut_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    wq(5);
    check(dut_oe == 1'b0, "R11", "SDA released in reset", dut_oe, 0);
    rst_n = 1'b1;
    wq(2);
    for (int a = 0; a < 256; a++) begin
      mem_we = 1'b1; mem_addr = 8'(a); mem_data = pat(a);
      wq(1);
    end
    mem_we = 1'b0;
    wq(Q);
    check(dut_oe == 1'b0, "R11", "SDA released after reset", dut_oe, 0);

    // R2 R11: counter starts at 0
    exp_addr = 0;
    open_read("R1"); read_seq(1, "R2"); bus_stop();
    // R3: continues at last+1 after NACK
    open_read("R1"); read_seq(1, "R3"); bus_stop();

    // R1: foreign address ignored
    bus_start();
    send_byte(8'h91, ack);
    check(!ack, "R1", "foreign header ack", ack, 0);
    idle_bits("R1");
    bus_stop();
    open_read("R1"); read_seq(1, "R3"); bus_stop();

    // R4 R6: random then sequential read
    set_addr(8'h40);
    open_read("R4"); read_seq(3, "R6");
    idle_bits("R8");
    bus_stop();
    open_read("R3"); read_seq(1, "R3"); bus_stop();

    // R5: data byte after address is not taken
    set_addr(8'h80);
    send_byte(8'h5A, ack);
    check(!ack, "R5", "write data ack", ack, 0);
    bus_stop();
    open_read("R5"); read_seq(1, "R5"); bus_stop();

    // R7: wrap through top of array
    set_addr(8'hFD);
    open_read("R7"); read_seq(5, "R7"); bus_stop();

    // R9: STOP and START mid-byte
    begin
      logic s;
      bus_start();
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
      bus_stop();
      open_read("R9"); read_seq(1, "R9"); bus_stop();
      bus_start();
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
      open_read("R9"); read_seq(1, "R9"); bus_stop();
    end

    // R6 R7: whole array in one burst, then wrapped continuation
    set_addr(0);
    open_read("R6"); read_seq(256, "R6"); bus_stop();
    open_read("R7"); read_seq(1, "R7"); bus_stop();

    check(r10_viol == 0, "R10", "SDA moved while SCL high", r10_viol, 0);
    finish_run();
  end
endmodule